// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block sits beside a free-running counter and timestamps transitions on one of several external input pins. A pin select chooses which synchronized pin is watched, an optional inversion flips its polarity, and a two-bit mode picks which transitions count as capture events: none, rising, falling or both. On each qualifying transition, the counter value present in that cycle is latched into a capture register, and a sticky edge flag is raised.

Software clears the flag with a one-cycle clear pulse. When reload-on-capture is enabled, the block also asks the counter to reinitialize. This request is asserted combinationally in the same cycle as the transition, so the counter reload and the capture latch happen on the same clock edge. The counter itself and any interrupt or DMA routing live outside this block.

Top module: `edge_capture`

## Requirements
- R1: While reset is asserted and immediately after it, `capture_o` is 0, `edge_flag_o` is 0 and `reload_req_o` is 0.
- R2: `edge_mode_i` is decoded as 0 = capture disabled, 1 = rising edge, 2 = falling edge, 3 = both edges. In mode 0, no transition causes a capture, a flag set or a reload request.
- R3: In mode 1, a 0-to-1 transition of the watched level latches `count_i` into `capture_o` on that clock edge. A 1-to-0 transition does not.
- R4: In mode 2, a 1-to-0 transition of the watched level latches `count_i`. A 0-to-1 transition does not.
- R5: In mode 3, both directions of transition latch `count_i`.
- R6: `pin_sel_i` (2 bits) selects `pins_i[pin_sel_i]` as the watched pin. Transitions on the other pins have no effect.
- R7: When `invert_i` is 1, the watched level is the complement of the selected pin. This level is computed before edge detection, so a falling pin edge is seen as rising.
- R8: Each transition produces at most one capture. A steady level causes no further capture, and `capture_o` holds its value until the next qualifying transition.
- R9: Every capture sets `edge_flag_o` on the same clock edge. The flag stays set until a cycle with `flag_clr_i` = 1 clears it.
- R10: If a clear pulse and a capture fall in the same cycle, the flag ends up set.
- R11: `reload_req_o` is 1 exactly in a cycle with a qualifying transition while `reload_en_i` is 1, and is 0 otherwise.
- R12: The first sample after reset only primes the edge detector. A pin that is already high at that point does not cause a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 4 | Synchronized input pins |
| count_i | input | 16 | Current counter value |
| pin_sel_i | input | 2 | Watched pin index |
| invert_i | input | 1 | Invert watched pin polarity |
| edge_mode_i | input | 2 | Capture edge type (0 off, 1 rise, 2 fall, 3 both) |
| reload_en_i | input | 1 | Request counter reload on capture |
| flag_clr_i | input | 1 | Clear pulse for the edge flag |
| capture_o | output | 16 | Latched counter value |
| edge_flag_o | output | 1 | Sticky input-edge flag |
| reload_req_o | output | 1 | Counter reload request, same cycle as the transition |

## Verification
The assertions assume that `pins_i` is already synchronized to `clk`. They also assume that the selection and inversion controls change only when the old and new watched levels agree. Otherwise, a reconfiguration is itself seen as a transition, which is consistent behaviour but not a pin event. The stimulus moves the pin select only while both the old and the new pin are low. It flips inversion only in a mode where the resulting apparent edge does not qualify, so every capture the bench expects comes from a real pin change.

// File: rtl/edge_capture_pkg.sv
package edge_capture_pkg;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_ANY  = 2'd3
  } cap_mode_e;

  // Decide whether a detected transition is a capture event under a mode.
  function automatic logic cap_qualifies(cap_mode_e mode, logic rise, logic fall);
    logic want_rise;
    logic want_fall;
    want_rise = (mode == CAP_RISE) || (mode == CAP_ANY);
    want_fall = (mode == CAP_FALL) || (mode == CAP_ANY);
    return (rise && want_rise) || (fall && want_fall);
  endfunction

endpackage

// File: rtl/ecap_pin_sel.sv
module ecap_pin_sel #(
  parameter int NPINS = 4,
  localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [NPINS-1:0] pins_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             invert_i,
  output logic             level_o
);
  always_comb begin
    level_o = pins_i[sel_i] ^ invert_i;
  end
endmodule

// File: rtl/ecap_edge_det.sv
module ecap_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= level_i;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    rise_o = primed_q && level_i && !prev_q;
    fall_o = primed_q && !level_i && prev_q;
  end
endmodule

// File: rtl/ecap_hold.sv
module ecap_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] capture_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (evt_i) cap_q <= count_i;
      flag_q <= evt_i || (flag_q && !clr_i);
    end
  end

  assign capture_o = cap_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/edge_capture.sv
module edge_capture
  import edge_capture_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NPINS = 4,
  localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [SEL_W-1:0] pin_sel_i,
  input  logic             invert_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             reload_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] capture_o,
  output logic             edge_flag_o,
  output logic             reload_req_o
);
  logic watched_lvl;
  logic lvl_rise;
  logic lvl_fall;
  logic cap_evt;

  ecap_pin_sel #(.NPINS(NPINS)) u_sel (
    .pins_i   (pins_i),
    .sel_i    (pin_sel_i),
    .invert_i (invert_i),
    .level_o  (watched_lvl)
  );

  ecap_edge_det u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (watched_lvl),
    .rise_o  (lvl_rise),
    .fall_o  (lvl_fall)
  );

  always_comb begin
    cap_evt = cap_qualifies(cap_mode_e'(edge_mode_i), lvl_rise, lvl_fall);
  end

  ecap_hold #(.CNT_W(CNT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (cap_evt),
    .count_i   (count_i),
    .clr_i     (flag_clr_i),
    .capture_o (capture_o),
    .flag_o    (edge_flag_o)
  );

  assign reload_req_o = cap_evt && reload_en_i;
endmodule

// File: rtl/edge_capture_chk.sv
module edge_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       edge_mode_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_i,
  input logic             cap_evt,
  input logic [CNT_W-1:0] capture_o,
  input logic             edge_flag_o,
  input logic             reload_req_o
);
  assert_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i == 2'd0) |-> !cap_evt);

  assert_capture_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (capture_o == $past(count_i)));

  assert_capture_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(capture_o));

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> edge_flag_o);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag_o && !flag_clr_i) |=> edge_flag_o);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !cap_evt) |=> !edge_flag_o);

  assert_reload_only_on_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req_o |-> cap_evt);
endmodule

bind edge_capture edge_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .edge_mode_i  (edge_mode_i),
  .flag_clr_i   (flag_clr_i),
  .count_i      (count_i),
  .cap_evt      (cap_evt),
  .capture_o    (capture_o),
  .edge_flag_o  (edge_flag_o),
  .reload_req_o (reload_req_o)
);

// File: tb/edge_capture_tb.sv
module edge_capture_tb;
  localparam int CNT_W = 16;
  localparam int NPINS = 4;
  localparam int NVEC  = 18;

  typedef struct packed {
    logic [3:0]  pins;
    logic [1:0]  sel;
    logic        inv;
    logic [1:0]  mode;
    logic        rel;
    logic        clr;
    logic [15:0] cnt;
    logic [15:0] ecap;
    logic        eflag;
    logic        erel;
    logic [3:0]  req;
  } vec_t;

  // pins, sel, inv, mode, rel, clr, count, exp capture, exp flag, exp reload, requirement
  localparam vec_t TBL [NVEC] = '{
    '{4'b0000, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h0011, 16'h0000, 1'b0, 1'b0, 4'd12}, // R12 prime
    '{4'b0001, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h1234, 16'h1234, 1'b1, 1'b1, 4'd3},  // R3 R11 rise
    '{4'b0001, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h2222, 16'h1234, 1'b1, 1'b0, 4'd8},  // R8 steady
    '{4'b0000, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h3333, 16'h1234, 1'b1, 1'b0, 4'd3},  // R3 fall ignored
    '{4'b0000, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 16'h4444, 16'h1234, 1'b0, 1'b0, 4'd9},  // R9 clear
    '{4'b0001, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h5555, 16'h1234, 1'b0, 1'b0, 4'd4},  // R4 rise ignored
    '{4'b0000, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 16'h6666, 16'h6666, 1'b1, 1'b1, 4'd4},  // R4 fall
    '{4'b0001, 2'd0, 1'b0, 2'd3, 1'b0, 1'b1, 16'h7777, 16'h7777, 1'b1, 1'b0, 4'd10}, // R10 R5
    '{4'b0000, 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 16'h8888, 16'h8888, 1'b1, 1'b0, 4'd5},  // R5 fall
    '{4'b0001, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 16'h9999, 16'h8888, 1'b0, 1'b0, 4'd2},  // R2 off
    '{4'b0000, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'hAAAA, 16'h8888, 1'b0, 1'b0, 4'd2},  // R2 off
    '{4'b0100, 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 16'hBBBB, 16'h8888, 1'b0, 1'b0, 4'd6},  // R6 other pin
    '{4'b0000, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 16'hCCCC, 16'h8888, 1'b0, 1'b0, 4'd6},  // R6 reselect
    '{4'b0100, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 16'hDDDD, 16'hDDDD, 1'b1, 1'b0, 4'd6},  // R6 pin 2 rise
    '{4'b0101, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 16'hD00D, 16'hDDDD, 1'b1, 1'b0, 4'd6},  // R6 pin 0 ignored
    '{4'b0101, 2'd2, 1'b1, 2'd1, 1'b0, 1'b1, 16'hEEEE, 16'hDDDD, 1'b0, 1'b0, 4'd7},  // R7 invert on
    '{4'b0001, 2'd2, 1'b1, 2'd1, 1'b0, 1'b0, 16'hF00F, 16'hF00F, 1'b1, 1'b0, 4'd7},  // R7 inverted rise
    '{4'b0101, 2'd2, 1'b1, 2'd1, 1'b0, 1'b0, 16'h0F0F, 16'hF00F, 1'b1, 1'b0, 4'd7}   // R7 inverted fall
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pins_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic [1:0]       pin_sel_i = '0;
  logic             invert_i = 1'b0;
  logic [1:0]       edge_mode_i = '0;
  logic             reload_en_i = 1'b0;
  logic             flag_clr_i = 1'b0;
  logic [CNT_W-1:0] capture_o;
  logic             edge_flag_o;
  logic             reload_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_capture #(.CNT_W(CNT_W), .NPINS(NPINS)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pins_i       (pins_i),
    .count_i      (count_i),
    .pin_sel_i    (pin_sel_i),
    .invert_i     (invert_i),
    .edge_mode_i  (edge_mode_i),
    .reload_en_i  (reload_en_i),
    .flag_clr_i   (flag_clr_i),
    .capture_o    (capture_o),
    .edge_flag_o  (edge_flag_o),
    .reload_req_o (reload_req_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, check reload before the edge and the latched state after it.
  task automatic step(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    pins_i = v.pins; pin_sel_i = v.sel; invert_i = v.inv; edge_mode_i = v.mode;
    reload_en_i = v.rel; flag_clr_i = v.clr; count_i = v.cnt;
    #1;
    check(tag, "reload_req", int'(reload_req_o), int'(v.erel));
    @(posedge clk);
    #1;
    check(tag, "capture", int'(capture_o), int'(v.ecap));
    check(tag, "edge_flag", int'(edge_flag_o), int'(v.eflag));
  endtask

  task automatic do_reset(input logic [NPINS-1:0] p);
    @(negedge clk);
    rst_n = 1'b0; pins_i = p; pin_sel_i = '0; invert_i = 1'b0;
    edge_mode_i = 2'd1; reload_en_i = 1'b1; flag_clr_i = 1'b0;
    @(posedge clk);
    #1;
    check("R1", "capture in reset", int'(capture_o), 0);
    check("R1", "flag in reset", int'(edge_flag_o), 0);
    check("R1", "reload in reset", int'(reload_req_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset(4'b0000);
    for (int i = 0; i < NVEC; i++) step(TBL[i]);

    // R1: reset in the middle of activity returns everything to zero.
    do_reset(4'b0001);
    // R12: pin already high at the first sample after reset is not an edge.
    step('{4'b0001, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h1357, 16'h0000, 1'b0, 1'b0, 4'd12});
    step('{4'b0000, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h2468, 16'h0000, 1'b0, 1'b0, 4'd12});
    // R11: rise with reload disabled captures without a reload request.
    step('{4'b0001, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'hBEEF, 16'hBEEF, 1'b1, 1'b0, 4'd11});
    // R8: held high for several cycles, no recapture.
    step('{4'b0001, 2'd0, 1'b0, 2'd3, 1'b1, 1'b0, 16'h0001, 16'hBEEF, 1'b1, 1'b0, 4'd8});
    step('{4'b0001, 2'd0, 1'b0, 2'd3, 1'b1, 1'b0, 16'h0002, 16'hBEEF, 1'b1, 1'b0, 4'd8});
    // R5: fall in both-edge mode with reload, then R9 clear.
    step('{4'b0000, 2'd0, 1'b0, 2'd3, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 4'd5});
    step('{4'b0000, 2'd0, 1'b0, 2'd3, 1'b0, 1'b1, 16'h0003, 16'hFFFF, 1'b0, 1'b0, 4'd9});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule